// File: doc/BRIEF.md
# Single-Channel DMA Sequencer with Guarded Enable

The block runs one DMA channel. Software programs a start address, a transfer count and an 8-bit control byte. It then sets the channel's enable bit through a guarded read-then-write sequence. After that, the channel waits for its selected request line. Each sampled request starts one bus cycle on a request/acknowledge handshake. Each acknowledge moves the address by one transfer unit and lowers the count.

At terminal count the channel takes one of two paths. In single-shot mode, hardware clears the enable bit and can flag a CPU interrupt. In repeat mode, the address and count return to their programmed start values and the channel stays armed. Arbitration with other channels and memory timing lie outside the block. The transfer direction on the bus is a build-time parameter.

Top module: `dmaChanEngine`

## Requirements
- R1: After reset, and one cycle after `standby` is asserted, the control byte reads 0x00 and `irq` is low.
- R2: Control byte fields are: bit 7 enable, bit 6 size (0 byte, 1 word), bit 5 direction (0 increment, 1 decrement), bit 4 repeat, bit 3 interrupt enable, bits 2..0 request-line index. `busWord` equals bit 6 during a bus cycle.
- R3: A write with bit 7 = 1 sets enable only if the control byte was read with enable = 0 since the last control write. Otherwise enable stays unchanged.
- R4: While enable is 0, or while the selected `reqVec` line is low, no bus cycle starts (`busReq` stays 0).
- R5: A request seen in the idle state with enable set raises `busReq` on the next cycle. `busReq` holds until `busAck`, and `busAddr` shows the current address throughout.
- R6: Each acknowledged transfer moves the address by 1 (byte) or 2 (word), up when bit 5 is 0 and down when bit 5 is 1, modulo 2^24.
- R7: Each acknowledged transfer lowers the count by 1. With repeat = 0, the transfer that brings the count from 1 to 0 clears enable.
- R8: With repeat = 1, the terminal transfer reloads the start address and start count. Enable stays 1 and no interrupt is raised.
- R9: A single-shot termination with interrupt enable = 1 raises `irq`. It stays high until a control write clears bit 3 or sets enable through the guarded sequence.
- R10: A control write with bit 7 = 0 clears enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Forces control byte and interrupt to zero |
| ctrlWr | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte write data |
| ctrlRd | input | 1 | Control byte read strobe (arms the enable guard) |
| ctrlRdData | output | 8 | Current control byte |
| addrWr | input | 1 | Loads current and start address |
| addrWrData | input | 24 | Address load value |
| cntWr | input | 1 | Loads current and start count |
| cntWrData | input | 16 | Count load value |
| reqVec | input | 8 | Activation request lines |
| busReq | output | 1 | Bus cycle request |
| busAck | input | 1 | Bus cycle acknowledge |
| busWrite | output | 1 | Bus cycle is a write |
| busWord | output | 1 | Bus cycle is word-sized |
| busAddr | output | 24 | Bus cycle address |
| curAddr | output | 24 | Current address register |
| curCount | output | 16 | Current transfer count |
| irq | output | 1 | CPU interrupt request |

## Verification
Faults in the address or count register show up at `curAddr`, `curCount` or the next bus cycle's `busAddr` on the first acknowledged transfer. A sequencer stuck busy or idle shows up as a missing or extra `busReq` one cycle after a request. A broken enable guard or terminal detect shows up in bit 7 of `ctrlRdData` and in `irq`. This happens in the cycle after the write or the final acknowledge. It can also show up as an unexpected transfer on the next request.

// File: rtl/dmaChanPkg.sv
package dmaChanPkg;
  typedef struct packed {
    logic step;    // advance address and count
    logic reload;  // restore start values
  } dpStrobes_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seqState_t;
endpackage

// File: rtl/dmaChanDatapath.sv
module dmaChanDatapath
  import dmaChanPkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobes_t    strb,
  input  logic          wordSize,
  input  logic          decMode,
  input  logic          addrWr,
  input  logic [AW-1:0] addrWrData,
  input  logic          cntWr,
  input  logic [CW-1:0] cntWrData,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count,
  output logic          cntIsLast
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] addrStart;
  logic [CW-1:0] cntStart;
  logic [AW-1:0] stepVal;

  assign stepVal   = wordSize ? STEP_W : STEP_B;
  assign cntIsLast = (count == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr      <= '0;
      addrStart <= '0;
      count     <= '0;
      cntStart  <= '0;
    end else begin
      if (addrWr) begin
        addr      <= addrWrData;
        addrStart <= addrWrData;
      end else if (strb.reload) begin
        addr <= addrStart;
      end else if (strb.step) begin
        addr <= decMode ? addr - stepVal : addr + stepVal;
      end
      if (cntWr) begin
        count    <= cntWrData;
        cntStart <= cntWrData;
      end else if (strb.reload) begin
        count <= cntStart;
      end else if (strb.step) begin
        count <= count - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dmaChanCtrl.sv
module dmaChanCtrl
  import dmaChanPkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               standby,
  input  logic               ctrlWr,
  input  logic [7:0]         ctrlWrData,
  input  logic               ctrlRd,
  input  logic [(1<<SRC_W)-1:0] reqVec,
  input  logic               busAck,
  input  logic               cntIsLast,
  output logic [7:0]         ctrlReg,
  output logic               busy,
  output logic               irqPend,
  output dpStrobes_t         strb
);
  localparam int BIT_EN  = 7;
  localparam int BIT_RPT = 4;
  localparam int BIT_IE  = 3;

  seqState_t state;
  logic      armed;
  logic      ackNow;
  logic      termNow;

  assign busy    = (state == ST_BUSY);
  assign ackNow  = busy && busAck;
  assign termNow = ackNow && cntIsLast;

  always_comb begin
    strb.reload = termNow && ctrlReg[BIT_RPT];
    strb.step   = ackNow && !strb.reload;
  end

  always_ff @(posedge clk) begin
    if (!rstN || standby) begin
      ctrlReg <= 8'h00;
      armed   <= 1'b0;
      state   <= ST_IDLE;
      irqPend <= 1'b0;
    end else begin
      if (ctrlRd && !ctrlReg[BIT_EN]) armed <= 1'b1;
      if (ctrlWr) begin
        ctrlReg[6:0]    <= ctrlWrData[6:0];
        ctrlReg[BIT_EN] <= ctrlWrData[BIT_EN] && (ctrlReg[BIT_EN] || armed);
        armed           <= 1'b0;
        if (!ctrlWrData[BIT_IE]) irqPend <= 1'b0;
        if (ctrlWrData[BIT_EN] && armed && !ctrlReg[BIT_EN]) irqPend <= 1'b0;
      end
      case (state)
        ST_IDLE: if (ctrlReg[BIT_EN] && reqVec[ctrlReg[SRC_W-1:0]]) state <= ST_BUSY;
        ST_BUSY: if (busAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (termNow && !ctrlReg[BIT_RPT]) begin
        ctrlReg[BIT_EN] <= 1'b0;
        if (ctrlReg[BIT_IE]) irqPend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmaChanEngine.sv
module dmaChanEngine
  import dmaChanPkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter bit XFER_WRITE = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          standby,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlWrData,
  input  logic          ctrlRd,
  output logic [7:0]    ctrlRdData,
  input  logic          addrWr,
  input  logic [AW-1:0] addrWrData,
  input  logic          cntWr,
  input  logic [CW-1:0] cntWrData,
  input  logic [7:0]    reqVec,
  output logic          busReq,
  input  logic          busAck,
  output logic          busWrite,
  output logic          busWord,
  output logic [AW-1:0] busAddr,
  output logic [AW-1:0] curAddr,
  output logic [CW-1:0] curCount,
  output logic          irq
);
  localparam int SRC_W = 3;

  dpStrobes_t strb;
  logic [7:0] ctrlReg;
  logic       busy;
  logic       cntIsLast;

  dmaChanCtrl #(.SRC_W(SRC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .standby(standby),
    .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData), .ctrlRd(ctrlRd),
    .reqVec(reqVec), .busAck(busAck), .cntIsLast(cntIsLast),
    .ctrlReg(ctrlReg), .busy(busy), .irqPend(irq), .strb(strb)
  );

  dmaChanDatapath #(.AW(AW), .CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wordSize(ctrlReg[6]), .decMode(ctrlReg[5]),
    .addrWr(addrWr), .addrWrData(addrWrData),
    .cntWr(cntWr), .cntWrData(cntWrData),
    .addr(curAddr), .count(curCount), .cntIsLast(cntIsLast)
  );

  assign ctrlRdData = ctrlReg;
  assign busReq     = busy;
  assign busWrite   = busy && XFER_WRITE;
  assign busWord    = busy && ctrlReg[6];
  assign busAddr    = curAddr;
endmodule

// File: rtl/dmaChanEngineChk.sv
module dmaChanEngineChk #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          standby,
  input logic          ctrlWr,
  input logic [7:0]    ctrlRdData,
  input logic          addrWr,
  input logic          cntWr,
  input logic          busReq,
  input logic          busAck,
  input logic [AW-1:0] curAddr,
  input logic [CW-1:0] curCount,
  input logic          irq
);
  // R1: standby clears control byte and interrupt
  a_r1_standby_clears: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (ctrlRdData == 8'h00 && !irq));

  // R3: enable only ever rises after a control write
  a_r3_enable_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlRdData[7]) |-> $past(ctrlWr));

  // R5: request holds until acknowledged
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !standby) |=> busReq);

  // R6: address steps on a non-terminal transfer
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && !standby && !addrWr && curCount != CW'(1)) |=>
      (curAddr == ($past(ctrlRdData[5]) ?
        $past(curAddr) - ($past(ctrlRdData[6]) ? AW'(2) : AW'(1)) :
        $past(curAddr) + ($past(ctrlRdData[6]) ? AW'(2) : AW'(1)))));

  // R7: single-shot terminal transfer clears enable
  a_r7_term_clears_en: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && !cntWr && curCount == CW'(1) && !ctrlRdData[4]) |=> !ctrlRdData[7]);

  // R8: repeat terminal transfer keeps enable and raises no interrupt
  a_r8_repeat_keeps_en: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && !standby && !ctrlWr && curCount == CW'(1) && ctrlRdData[4] && !irq)
      |=> (ctrlRdData[7] && !irq));
endmodule

bind dmaChanEngine dmaChanEngineChk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .standby(standby), .ctrlWr(ctrlWr),
  .ctrlRdData(ctrlRdData), .addrWr(addrWr), .cntWr(cntWr),
  .busReq(busReq), .busAck(busAck), .curAddr(curAddr),
  .curCount(curCount), .irq(irq)
);

// File: tb/dmaChanEngine_tb.sv
module dmaChanEngine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 1'b0;
  logic ctrlWr = 1'b0, ctrlRd = 1'b0, addrWr = 1'b0, cntWr = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [7:0] ctrlRdData;
  logic [AW-1:0] addrWrData = '0;
  logic [CW-1:0] cntWrData = '0;
  logic [7:0] reqVec = '0;
  logic busReq, busAck = 1'b0, busWrite, busWord, irq;
  logic [AW-1:0] busAddr, curAddr;
  logic [CW-1:0] curCount;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaChanEngine dut_i (
    .clk(clk), .rstN(rstN), .standby(standby),
    .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData), .ctrlRd(ctrlRd), .ctrlRdData(ctrlRdData),
    .addrWr(addrWr), .addrWrData(addrWrData), .cntWr(cntWr), .cntWrData(cntWrData),
    .reqVec(reqVec), .busReq(busReq), .busAck(busAck), .busWrite(busWrite),
    .busWord(busWord), .busAddr(busAddr), .curAddr(curAddr), .curCount(curCount), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nextAddr(input logic [AW-1:0] a, input logic word, input logic dec);
    logic [AW-1:0] s;
    s = word ? AW'(2) : AW'(1);
    return dec ? a - s : a + s;
  endfunction

  task automatic wrCtrl(input logic [7:0] d);
    ctrlWrData = d; ctrlWr = 1'b1;
    @(negedge clk); ctrlWr = 1'b0;
  endtask

  task automatic rdCtrl(output logic [7:0] d);
    ctrlRd = 1'b1; d = ctrlRdData;
    @(negedge clk); ctrlRd = 1'b0;
  endtask

  task automatic loadRegs(input logic [AW-1:0] a, input logic [CW-1:0] c);
    addrWrData = a; addrWr = 1'b1; cntWrData = c; cntWr = 1'b1;
    @(negedge clk); addrWr = 1'b0; cntWr = 1'b0;
  endtask

  // pulse request; expect a bus cycle at address expA
  task automatic doXfer(input int src, input logic [AW-1:0] expA, input logic word);
    reqVec[src] = 1'b1;
    @(negedge clk); reqVec = '0;
    check("R5 busReq", busReq, 1'b1);
    check("R5 busAddr", busAddr, expA);
    check("R2 busWord", busWord, word);
    busAck = 1'b1;
    @(negedge clk); busAck = 1'b0;
    check("R5 busReq drop", busReq, 1'b0);
  endtask

  task automatic noXfer(input string req, input int src);
    reqVec[src] = 1'b1;
    @(negedge clk); reqVec = '0;
    check(req, busReq, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [AW-1:0] eA, a0;
    logic [CW-1:0] eC, c0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset ctrl", ctrlRdData, 8'h00);
    check("R1 reset irq", irq, 1'b0);

    // R3: write 1 without a prior read of 0
    loadRegs(24'h000100, 16'd3);
    wrCtrl(8'h80);
    check("R3 unguarded write", ctrlRdData[7], 1'b0);
    noXfer("R4 disabled ignores req", 0);

    // R3: guarded sequence, source 5
    rdCtrl(rd);
    check("R3 read shows disabled", rd[7], 1'b0);
    wrCtrl(8'h85);
    check("R3 guarded write", ctrlRdData, 8'h85);
    noXfer("R4 unselected line ignored", 2);
    doXfer(5, 24'h000100, 1'b0);
    check("R6 inc byte", curAddr, 24'h000101);
    check("R7 count dec", curCount, 16'd2);

    // R10: write 0 clears enable
    wrCtrl(8'h05);
    check("R10 write 0 clears", ctrlRdData[7], 1'b0);
    noXfer("R4 after clear", 5);

    // R1: standby
    rdCtrl(rd); wrCtrl(8'h8D);
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    check("R1 standby clears", ctrlRdData, 8'h00);

    // random configurations
    for (int it = 0; it < 24; it++) begin
      logic word, dec, rpt;
      int src, n;
      word = 1'($urandom); dec = 1'($urandom); rpt = 1'($urandom);
      src = $urandom % 8;
      if (it == 0) a0 = 24'h000000; else if (it == 1) a0 = 24'hFFFFFF; else a0 = 24'($urandom);
      if (it < 2) begin dec = (it == 0); rpt = 1'b0; end
      c0 = CW'(1 + ($urandom % 4));
      loadRegs(a0, c0);
      rdCtrl(rd);
      wrCtrl({1'b1, word, dec, rpt, 1'b1, 3'(src)});
      check("R3 enable set", ctrlRdData[7], 1'b1);
      eA = a0; eC = c0;
      n = rpt ? int'(c0) + 2 : int'(c0);
      for (int k = 0; k < n; k++) begin
        doXfer(src, eA, word);
        if (eC == 1 && rpt) begin eA = a0; eC = c0; end
        else begin eA = nextAddr(eA, word, dec); eC = eC - 1'b1; end
        check(rpt ? "R8 addr" : "R6 addr", curAddr, eA);
        check(rpt ? "R8 count" : "R7 count", curCount, eC);
      end
      if (rpt) begin
        check("R8 enable kept", ctrlRdData[7], 1'b1);
        check("R8 no irq", irq, 1'b0);
        wrCtrl({1'b0, word, dec, rpt, 1'b1, 3'(src)});
        check("R10 disable", ctrlRdData[7], 1'b0);
      end else begin
        check("R7 enable cleared", ctrlRdData[7], 1'b0);
        check("R9 irq raised", irq, 1'b1);
        noXfer("R4 after terminal", src);
        check("R9 irq held", irq, 1'b1);
        if (it % 2 == 0) begin
          wrCtrl({1'b0, word, dec, rpt, 1'b0, 3'(src)});
          check("R9 irq cleared by IE=0", irq, 1'b0);
        end else begin
          loadRegs(a0, 16'd1);
          rdCtrl(rd);
          wrCtrl({1'b1, word, dec, rpt, 1'b1, 3'(src)});
          check("R9 irq cleared by enable", irq, 1'b0);
          doXfer(src, a0, word);
          check("R9 irq again", irq, 1'b1);
          wrCtrl(8'h00);
        end
      end
    end

    // R9: termination with IE=0 raises no irq
    loadRegs(24'h000010, 16'd1);
    rdCtrl(rd); wrCtrl(8'h80);
    doXfer(0, 24'h000010, 1'b0);
    check("R7 terminal clears", ctrlRdData[7], 1'b0);
    check("R9 no irq when IE=0", irq, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule